// File: doc/BRIEF.md
# Time-of-Day Counter with Cross-Domain Capture

This block keeps time in the reference clock domain as two counters: a whole-second count and a count of reference ticks inside the current second. With the default 125 MHz reference, one tick is 8 ns. When the tick count reaches its last value, the next edge sets it back to zero and adds one to the seconds count. A load strobe sets the seconds count directly and starts the second over at tick zero.

A sampling domain with its own unrelated clock, such as an ADC strobe, can ask for a timestamp with a single-cycle trigger pulse. The pulse crosses into the reference domain through a toggle handshake. On the first reference edge that sees it, the live pair is latched into a capture register and a valid flag is raised. Software clears the flag. If a trigger arrives while the handshake is still busy, that trigger is dropped and a sticky overrun flag is raised.

Top module: `tai_time_capture`

## Requirements
- R1: Out of reset and with no load, `now_cyc` grows by exactly one on every `clk_ref` rising edge, and `now_sec` holds its value.
- R2: On an edge where `now_cyc` equals `CYC_MAX` (default 124999999), `now_cyc` becomes 0 and `now_sec` grows by one on that same edge.
- R3: On an edge where `load_en` is 1, `now_sec` takes `load_sec` and `now_cyc` becomes 0. This takes priority over the wrap of R2.
- R4: Each `trig_clk` cycle with `trig_in` at 1 is one trigger request. An accepted trigger causes exactly one capture, no later than the fifth `clk_ref` edge after the `trig_clk` edge that sampled it. The captured pair equals the live pair shown during the reference cycle just before the capture edge.
- R5: A capture that lands on a wrap edge or a load edge records the pair of one single cycle, so `cap_cyc` never exceeds `CYC_MAX`.
- R6: `cap_valid` is 1 after every capture edge. Otherwise it goes to 0 after an edge where `cap_clear` is 1. When a capture and a clear fall on the same edge, the capture wins.
- R7: A trigger that arrives while an earlier one is still in the handshake makes no capture. Within eight reference cycles it sets `cap_overrun`, which stays at 1 until `trig_rst_n` is asserted.
- R8: While `rst_ref_n` and `trig_rst_n` are low, every output is 0.
- R9: A capture while `cap_valid` is already 1 overwrites the captured pair with the new time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all counters run on it |
| rst_ref_n | input | 1 | Asynchronous active-low reset, reference domain |
| load_en | input | 1 | Load the seconds count and restart the second |
| load_sec | input | SEC_W | Seconds value to load |
| cap_clear | input | 1 | Clear the capture valid flag |
| trig_clk | input | 1 | Clock of the sampling domain |
| trig_rst_n | input | 1 | Asynchronous active-low reset, sampling domain |
| trig_in | input | 1 | Trigger request, one per high cycle of trig_clk |
| now_sec | output | SEC_W | Live seconds count |
| now_cyc | output | CYC_W | Live tick count within the second |
| cap_sec | output | SEC_W | Captured seconds |
| cap_cyc | output | CYC_W | Captured ticks |
| cap_valid | output | 1 | A capture is held and has not been cleared |
| cap_overrun | output | 1 | Sticky: a trigger was dropped while busy |

## Verification
A capture can fall on the same reference edge as a wrap, a load, or a software clear. These are the cases where the pair could be torn or the flag could be lost. The bench uses a small `CYC_MAX` so that wraps come often. It triggers from an unrelated 13 ns clock, sweeping the trigger offset so that captures land before, on and after wraps and load strobes. It also pulses `cap_clear` at a range of offsets after a trigger. A behavioural model predicts the live time and the valid flag on every clock. Each capture is judged against the live pair seen one cycle earlier, against the `CYC_MAX` bound, and against the capture-wins rule.

// File: rtl/tai_pkg.sv
package tai_pkg;
    localparam int DEF_SEC_W   = 40;
    localparam int DEF_CYC_W   = 28;
    localparam int DEF_CYC_MAX = 124999999;
    localparam int DEF_STAGES  = 2;
endpackage

// File: rtl/tai_counter.sv
module tai_counter #(
    parameter int SEC_W   = 40,
    parameter int CYC_W   = 28,
    parameter int CYC_MAX = 124999999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    output logic [SEC_W-1:0] sec,
    output logic [CYC_W-1:0] cyc
);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_MAX);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [CYC_W-1:0] cyc;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_en) begin
            cnt_d.sec = load_sec;
            cnt_d.cyc = '0;
        end else if (cnt_q.cyc == CYC_LAST) begin
            cnt_d.sec = cnt_q.sec + 1'b1;
            cnt_d.cyc = '0;
        end else begin
            cnt_d.cyc = cnt_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sec = cnt_q.sec;
    assign cyc = cnt_q.cyc;
endmodule

// File: rtl/tai_pulse_sync.sv
module tai_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse,
    output logic dst_overrun
);
    localparam int NS = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic          req;
        logic          ovr;
        logic [NS-1:0] ack_sync;
    } src_t;

    typedef struct packed {
        logic [NS-1:0] req_sync;
        logic          seen;
        logic [NS-1:0] ovr_sync;
    } dst_t;

    src_t src_d, src_q;
    dst_t dst_d, dst_q;
    logic busy;

    // source side: toggle request, drop and flag while the handshake is open
    always_comb begin
        src_d          = src_q;
        busy           = src_q.req ^ src_q.ack_sync[NS-1];
        src_d.ack_sync = {src_q.ack_sync[NS-2:0], dst_q.seen};
        if (src_pulse) begin
            if (busy) src_d.ovr = 1'b1;
            else      src_d.req = ~src_q.req;
        end
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) src_q <= '0;
        else            src_q <= src_d;
    end

    // destination side: synchronise the toggle, detect its change
    always_comb begin
        dst_d          = dst_q;
        dst_d.req_sync = {dst_q.req_sync[NS-2:0], src_q.req};
        dst_d.seen     = dst_q.req_sync[NS-1];
        dst_d.ovr_sync = {dst_q.ovr_sync[NS-2:0], src_q.ovr};
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) dst_q <= '0;
        else            dst_q <= dst_d;
    end

    assign dst_pulse   = dst_q.req_sync[NS-1] ^ dst_q.seen;
    assign dst_overrun = dst_q.ovr_sync[NS-1];
endmodule

// File: rtl/tai_capture.sv
module tai_capture #(
    parameter int SEC_W = 40,
    parameter int CYC_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             clear,
    input  logic [SEC_W-1:0] live_sec,
    input  logic [CYC_W-1:0] live_cyc,
    output logic [SEC_W-1:0] cap_sec,
    output logic [CYC_W-1:0] cap_cyc,
    output logic             cap_valid
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [CYC_W-1:0] cyc;
        logic             valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (hit) begin
            cap_d.sec   = live_sec;
            cap_d.cyc   = live_cyc;
            cap_d.valid = 1'b1;
        end else if (clear) begin
            cap_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_sec   = cap_q.sec;
    assign cap_cyc   = cap_q.cyc;
    assign cap_valid = cap_q.valid;
endmodule

// File: rtl/tai_time_capture.sv
module tai_time_capture #(
    parameter int SEC_W   = tai_pkg::DEF_SEC_W,
    parameter int CYC_W   = tai_pkg::DEF_CYC_W,
    parameter int CYC_MAX = tai_pkg::DEF_CYC_MAX,
    parameter int STAGES  = tai_pkg::DEF_STAGES
) (
    input  logic             clk_ref,
    input  logic             rst_ref_n,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    input  logic             cap_clear,
    input  logic             trig_clk,
    input  logic             trig_rst_n,
    input  logic             trig_in,
    output logic [SEC_W-1:0] now_sec,
    output logic [CYC_W-1:0] now_cyc,
    output logic [SEC_W-1:0] cap_sec,
    output logic [CYC_W-1:0] cap_cyc,
    output logic             cap_valid,
    output logic             cap_overrun
);
    logic cap_hit;

    tai_counter #(.SEC_W(SEC_W), .CYC_W(CYC_W), .CYC_MAX(CYC_MAX)) u_cnt (
        .clk      (clk_ref),
        .rst_n    (rst_ref_n),
        .load_en  (load_en),
        .load_sec (load_sec),
        .sec      (now_sec),
        .cyc      (now_cyc)
    );

    tai_pulse_sync #(.STAGES(STAGES)) u_sync (
        .src_clk     (trig_clk),
        .src_rst_n   (trig_rst_n),
        .src_pulse   (trig_in),
        .dst_clk     (clk_ref),
        .dst_rst_n   (rst_ref_n),
        .dst_pulse   (cap_hit),
        .dst_overrun (cap_overrun)
    );

    tai_capture #(.SEC_W(SEC_W), .CYC_W(CYC_W)) u_cap (
        .clk       (clk_ref),
        .rst_n     (rst_ref_n),
        .hit       (cap_hit),
        .clear     (cap_clear),
        .live_sec  (now_sec),
        .live_cyc  (now_cyc),
        .cap_sec   (cap_sec),
        .cap_cyc   (cap_cyc),
        .cap_valid (cap_valid)
    );
endmodule

// File: rtl/tai_time_capture_chk.sv
module tai_time_capture_chk #(
    parameter int SEC_W   = 40,
    parameter int CYC_W   = 28,
    parameter int CYC_MAX = 124999999
) (
    input logic             clk_ref,
    input logic             rst_ref_n,
    input logic             trig_rst_n,
    input logic             load_en,
    input logic [SEC_W-1:0] load_sec,
    input logic             cap_clear,
    input logic             cap_hit,
    input logic [SEC_W-1:0] now_sec,
    input logic [CYC_W-1:0] now_cyc,
    input logic [SEC_W-1:0] cap_sec,
    input logic [CYC_W-1:0] cap_cyc,
    input logic             cap_valid,
    input logic             cap_overrun
);
    localparam logic [CYC_W-1:0] LAST = CYC_W'(CYC_MAX);

    assert_tick_step_R1: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        (!load_en && now_cyc != LAST) |=> (now_cyc == $past(now_cyc) + 1'b1) && $stable(now_sec));

    assert_wrap_carry_R2: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        (!load_en && now_cyc == LAST) |=> (now_cyc == '0) && (now_sec == $past(now_sec) + 1'b1));

    assert_load_R3: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        load_en |=> (now_cyc == '0) && (now_sec == $past(load_sec)));

    assert_capture_pair_R4: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        cap_hit |=> cap_valid && (cap_sec == $past(now_sec)) && (cap_cyc == $past(now_cyc)));

    assert_cap_bound_R5: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        cap_valid |-> cap_cyc <= LAST);

    assert_clear_R6: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        (cap_clear && !cap_hit) |=> !cap_valid);

    assert_overrun_sticky_R7: assert property (@(posedge clk_ref) disable iff (!rst_ref_n || !trig_rst_n)
        cap_overrun |=> cap_overrun);
endmodule

bind tai_time_capture tai_time_capture_chk #(
    .SEC_W(SEC_W), .CYC_W(CYC_W), .CYC_MAX(CYC_MAX)
) u_chk (.*);

// File: tb/tai_time_capture_bench.sv
module tai_time_capture_bench;
    localparam int REF_PERIOD  = 8;
    localparam int TRIG_PERIOD = 13;
    localparam int SEC_W       = 40;
    localparam int CYC_W       = 28;
    localparam int CYC_MAX     = 24;
    localparam int STAGES      = 2;

    logic             clk_ref = 1'b0;
    logic             trig_clk = 1'b0;
    logic             rst_ref_n = 1'b0;
    logic             trig_rst_n = 1'b0;
    logic             load_en = 1'b0;
    logic [SEC_W-1:0] load_sec = '0;
    logic             cap_clear = 1'b0;
    logic             trig_in = 1'b0;
    logic [SEC_W-1:0] now_sec, cap_sec;
    logic [CYC_W-1:0] now_cyc, cap_cyc;
    logic             cap_valid, cap_overrun;

    tai_time_capture #(.SEC_W(SEC_W), .CYC_W(CYC_W), .CYC_MAX(CYC_MAX), .STAGES(STAGES))
    u_tai_time_capture (
        .clk_ref, .rst_ref_n, .load_en, .load_sec, .cap_clear,
        .trig_clk, .trig_rst_n, .trig_in,
        .now_sec, .now_cyc, .cap_sec, .cap_cyc, .cap_valid, .cap_overrun
    );

    always #(REF_PERIOD/2) clk_ref = ~clk_ref;
    initial begin
        #3;
        forever #(TRIG_PERIOD/2.0) trig_clk = ~trig_clk;
    end

    int total = 0;
    int bad = 0;
    int ref_idx = 0;
    int captures = 0;
    int trig_idx = 0;
    bit done = 0;

    // behavioural model state
    longint m_sec = 0;
    longint m_cyc = 0;
    bit     m_valid = 0;
    bit     clr_seen = 0;
    longint prev_live_sec = 0, prev_live_cyc = 0;
    longint prev_cap_sec = 0, prev_cap_cyc = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk_ref) begin
        ref_idx++;
        clr_seen = cap_clear;
        if (!rst_ref_n) begin
            m_sec = 0; m_cyc = 0;
        end else if (load_en) begin
            m_sec = longint'(load_sec); m_cyc = 0;
        end else if (m_cyc == CYC_MAX) begin
            m_sec++; m_cyc = 0;
        end else begin
            m_cyc++;
        end
    end

    always @(negedge clk_ref) begin
        if (!rst_ref_n) begin
            check(now_sec == 0 && now_cyc == 0 && cap_sec == 0 && cap_cyc == 0
                  && !cap_valid && !cap_overrun, "R8 reset state",
                  {now_cyc, cap_valid, cap_overrun}, 0);
        end else begin
            bit changed;
            check(longint'(now_sec) == m_sec, "R1/R2/R3 live seconds", now_sec, m_sec);
            check(longint'(now_cyc) == m_cyc, "R1/R2/R3 live cycles", now_cyc, m_cyc);
            changed = (longint'(cap_sec) != prev_cap_sec) || (longint'(cap_cyc) != prev_cap_cyc);
            if (changed) begin
                captures++;
                check(longint'(cap_sec) == prev_live_sec, "R4 captured seconds", cap_sec, prev_live_sec);
                check(longint'(cap_cyc) == prev_live_cyc, "R4 captured cycles", cap_cyc, prev_live_cyc);
                check(cap_cyc <= CYC_MAX, "R5 consistent pair", cap_cyc, CYC_MAX);
                check((ref_idx - trig_idx) >= 1 && (ref_idx - trig_idx) <= STAGES + 3,
                      "R4 latency", ref_idx - trig_idx, STAGES + 1);
                m_valid = 1;
            end else if (clr_seen) begin
                m_valid = 0;
            end
            check(cap_valid == m_valid, "R6 valid flag", cap_valid, m_valid);
        end
        prev_live_sec = longint'(now_sec);
        prev_live_cyc = longint'(now_cyc);
        prev_cap_sec  = longint'(cap_sec);
        prev_cap_cyc  = longint'(cap_cyc);
    end

    task automatic ref_wait(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic trigger(input int cycles_high);
        @(negedge trig_clk);
        trig_in = 1'b1;
        @(posedge trig_clk);
        trig_idx = ref_idx;
        repeat (cycles_high) @(negedge trig_clk);
        trig_in = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk_ref) cap_clear = 1'b1;
        @(negedge clk_ref) cap_clear = 1'b0;
    endtask

    task automatic pulse_load(input logic [SEC_W-1:0] v);
        @(negedge clk_ref) begin load_sec = v; load_en = 1'b1; end
        @(negedge clk_ref) load_en = 1'b0;
    endtask

    initial begin
        #(REF_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        ref_wait(4);
        rst_ref_n = 1'b1; trig_rst_n = 1'b1;
        ref_wait(60);                               // R1, R2 across several wraps

        base = captures;
        trigger(1); ref_wait(12);
        check(captures == base + 1, "R4 single capture", captures, base + 1);
        pulse_clear(); ref_wait(2);                  // R6 clear

        for (int i = 0; i < 12; i++) begin           // R5, R9 sweep around wraps
            base = captures;
            #(i * 3);
            trigger(1); ref_wait(14 + i);
            check(captures == base + 1, "R9 capture over valid", captures, base + 1);
        end

        pulse_load(40'h12_3456_789A); ref_wait(3);   // R3
        for (int off = 0; off < 6; off++) begin      // R3/R5 capture near load
            base = captures;
            fork
                trigger(1);
                begin ref_wait(off); pulse_load(40'hFF_0000_0000 + 40'(off)); end
            join
            ref_wait(10);
            check(captures == base + 1, "R5 capture near load", captures, base + 1);
        end

        for (int off = 0; off < 7; off++) begin      // R6 clear vs capture
            fork
                trigger(1);
                begin ref_wait(off); pulse_clear(); end
            join
            ref_wait(10);
        end

        check(cap_overrun == 1'b0, "R7 overrun idle", cap_overrun, 0);
        base = captures;
        trigger(2); ref_wait(14);                    // second high cycle is dropped
        check(captures == base + 1, "R7 dropped trigger", captures, base + 1);
        check(cap_overrun == 1'b1, "R7 overrun set", cap_overrun, 1);
        trigger(1); ref_wait(20);
        check(cap_overrun == 1'b1, "R7 overrun sticky", cap_overrun, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule